// File: doc/BRIEF.md
# Pulse Burst Timing Controller

This block sequences a burst of radar transmit pulses. Software raises a trigger bit; on the rising edge, the controller takes a snapshot of the pulse width, the repetition interval, the pulse count and the two chirp settings. It then steps through the burst with no further help from software. For every repetition interval it drives a transmit gate that is high for the pulse width and low for the rest of the interval. It also issues a one-cycle strobe so that the downstream chirp generator restarts its sweep at the start of every pulse.

When the last interval of the burst ends, the controller parks in a finished state. It stays there until software clears the trigger bit, and then returns to idle, ready for the next edge. Settings written while a burst runs do not affect that burst, because only the snapshot taken at the edge is used.

Top module: `pulse_burst_ctrl`

## Requirements
- R1: After reset, tx_active, pulse_start, burst_busy and burst_done are all 0, chirp_fstart and chirp_step are 0, and the controller is idle.
- R2: A 0-to-1 change of trig_bit seen at a clock edge while idle starts a burst. In the next cycle tx_active and pulse_start are 1. A trigger level that stays high starts nothing further.
- R3: The repetition interval is P cycles and the pulse width is W cycles, both as latched. Within each interval, tx_active is 1 for the first W cycles and 0 for the remaining P-W cycles.
- R4: pulse_start is 1 for exactly one cycle, the first cycle of every pulse, and is 0 at all other times.
- R5: After cfg_count intervals, the last one including its idle tail, burst_busy falls to 0 and burst_done rises to 1 in the same cycle.
- R6: burst_done stays 1 while trig_bit stays 1. In the cycle after trig_bit is seen at 0, the controller is idle again with burst_done at 0.
- R7: If cfg_pri is less than or equal to the effective width, the interval used is width+1, so each pulse is followed by at least one idle cycle. A cfg_width of 0 is treated as 1.
- R8: A trigger edge with cfg_count equal to 0 produces no pulse. burst_done rises in the cycle after the edge, and burst_busy stays 0.
- R9: chirp_fstart and chirp_step show the values latched at the start of the burst. Changes to any cfg input, and a low-then-high toggle of trig_bit, during a burst have no effect until the next burst.
- R10: burst_busy is 1 from the cycle of the first pulse until the last interval ends, and tx_active is never 1 while burst_busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_bit | input | 1 | Software trigger level; a rising edge starts a burst |
| cfg_width | input | CW | Pulse width in cycles |
| cfg_pri | input | CW | Repetition interval in cycles |
| cfg_count | input | NW | Number of pulses in the burst |
| cfg_fstart | input | PW | Chirp start phase increment |
| cfg_step | input | PW | Chirp increment step |
| tx_active | output | 1 | Transmit gate |
| pulse_start | output | 1 | One-cycle chirp restart strobe |
| chirp_fstart | output | PW | Latched start increment for the chirp generator |
| chirp_step | output | PW | Latched step for the chirp generator |
| burst_busy | output | 1 | Burst in progress |
| burst_done | output | 1 | Burst finished; waiting for the trigger to clear |

## Verification
The bench runs bursts with a wide idle gap (width 3 in an interval of 8), with an interval equal to the width, and with a zero width, so it can tell real clamping from a gate that simply runs on. A single-cycle pulse in a two-cycle interval exposes off-by-one errors at the interval wrap. A zero-count burst separates an empty burst from a one-pulse burst. In one burst the settings are rewritten and the trigger is toggled mid-burst; the expected stream is built from the original snapshot, so any leak of live settings or any restart shows up as a mismatch. Holding the trigger high after a burst, and then starting a second burst with new chirp values, shows both the wait in the finished state and a fresh snapshot.

// File: rtl/pbc_pkg.sv
package pbc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_DONE   = 2'd2
  } burst_state_t;
endpackage

// File: rtl/pbc_trig_edge.sv
module pbc_trig_edge (
  input  logic clk,
  input  logic rst,
  input  logic level_in,
  output logic rise
);
  logic level_q;

  always_ff @(posedge clk) begin
    if (rst) level_q <= 1'b0;
    else     level_q <= level_in;
  end

  assign rise = level_in & ~level_q;
endmodule

// File: rtl/pbc_param_latch.sv
module pbc_param_latch #(
  parameter int CW = 16,
  parameter int NW = 8,
  parameter int PW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] cfg_width,
  input  logic [CW-1:0] cfg_pri,
  input  logic [NW-1:0] cfg_count,
  input  logic [PW-1:0] cfg_fstart,
  input  logic [PW-1:0] cfg_step,
  output logic [CW-1:0] width_q,
  output logic [CW:0]   pri_q,
  output logic [NW-1:0] count_q,
  output logic [PW-1:0] fstart_q,
  output logic [PW-1:0] step_q
);
  logic [CW-1:0] width_eff;
  logic [CW:0]   pri_eff;

  // zero width behaves as one cycle; interval must leave an idle cycle
  always_comb begin
    width_eff = (cfg_width == '0) ? CW'(1) : cfg_width;
    if ({1'b0, cfg_pri} <= {1'b0, width_eff})
      pri_eff = {1'b0, width_eff} + (CW+1)'(1);
    else
      pri_eff = {1'b0, cfg_pri};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      width_q  <= CW'(1);
      pri_q    <= (CW+1)'(2);
      count_q  <= '0;
      fstart_q <= '0;
      step_q   <= '0;
    end else if (load) begin
      width_q  <= width_eff;
      pri_q    <= pri_eff;
      count_q  <= cfg_count;
      fstart_q <= cfg_fstart;
      step_q   <= cfg_step;
    end
  end

  // R7: the latched interval always leaves an idle cycle after the pulse
  a_r7_idle_gap: assert property (@(posedge clk) disable iff (rst)
    pri_q > {1'b0, width_q});
  // R7: the latched width is never zero
  a_r7_width_nonzero: assert property (@(posedge clk) disable iff (rst)
    width_q != '0);
endmodule

// File: rtl/pbc_pri_timer.sv
module pbc_pri_timer #(
  parameter int CW = 16,
  parameter int NW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] width,
  input  logic [CW:0]   pri,
  input  logic [NW-1:0] count,
  output logic          tx_active,
  output logic          pulse_start,
  output logic          finish
);
  logic          run;
  logic [CW:0]   pos_q;
  logic [NW-1:0] idx_q;
  logic [CW:0]   pos_nxt;
  logic          wrap;
  logic          last;

  assign pos_nxt = pos_q + (CW+1)'(1);
  assign wrap    = (pos_nxt == pri);
  assign last    = (idx_q == count - NW'(1));
  assign finish  = run & wrap & last;

  always_ff @(posedge clk) begin
    if (rst) begin
      run         <= 1'b0;
      pos_q       <= '0;
      idx_q       <= '0;
      tx_active   <= 1'b0;
      pulse_start <= 1'b0;
    end else if (start) begin
      run         <= 1'b1;
      pos_q       <= '0;
      idx_q       <= '0;
      tx_active   <= 1'b1;
      pulse_start <= 1'b1;
    end else if (run) begin
      if (wrap && last) begin
        run         <= 1'b0;
        pos_q       <= '0;
        tx_active   <= 1'b0;
        pulse_start <= 1'b0;
      end else if (wrap) begin
        pos_q       <= '0;
        idx_q       <= idx_q + NW'(1);
        tx_active   <= 1'b1;
        pulse_start <= 1'b1;
      end else begin
        pos_q       <= pos_nxt;
        tx_active   <= (pos_nxt < {1'b0, width});
        pulse_start <= 1'b0;
      end
    end else begin
      tx_active   <= 1'b0;
      pulse_start <= 1'b0;
    end
  end

  // R4: the strobe only appears together with the gate
  a_r4_strobe_in_gate: assert property (@(posedge clk) disable iff (rst)
    pulse_start |-> tx_active);
  // R4: every rise of the gate carries the strobe
  a_r4_rise_strobe: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_active) |-> pulse_start);
  // R7: each pulse is preceded by a low gate cycle
  a_r7_gap_before_pulse: assert property (@(posedge clk) disable iff (rst)
    pulse_start |-> !$past(tx_active));
endmodule

// File: rtl/pbc_burst_fsm.sv
module pbc_burst_fsm
  import pbc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic rise,
  input  logic trig_level,
  input  logic count_zero,
  input  logic finish,
  output logic load,
  output logic start_timer,
  output logic busy,
  output logic done
);
  burst_state_t state_q, state_d;

  always_comb begin
    state_d     = state_q;
    load        = 1'b0;
    start_timer = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (rise) begin
          load = 1'b1;
          if (count_zero) begin
            state_d = ST_DONE;
          end else begin
            state_d     = ST_ACTIVE;
            start_timer = 1'b1;
          end
        end
      end
      ST_ACTIVE: if (finish)      state_d = ST_DONE;
      ST_DONE:   if (!trig_level) state_d = ST_IDLE;
      default:                    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      busy    <= (state_d == ST_ACTIVE);
      done    <= (state_d == ST_DONE);
    end
  end

  // R6: the finished state is held while the trigger stays high
  a_r6_done_hold: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DONE && trig_level) |=> (state_q == ST_DONE));
  // R2: a running burst never drops straight back to idle
  a_r2_no_abort: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ACTIVE) |=> (state_q != ST_IDLE));
endmodule

// File: rtl/pulse_burst_ctrl.sv
module pulse_burst_ctrl #(
  parameter int CW = 16,
  parameter int NW = 8,
  parameter int PW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          trig_bit,
  input  logic [CW-1:0] cfg_width,
  input  logic [CW-1:0] cfg_pri,
  input  logic [NW-1:0] cfg_count,
  input  logic [PW-1:0] cfg_fstart,
  input  logic [PW-1:0] cfg_step,
  output logic          tx_active,
  output logic          pulse_start,
  output logic [PW-1:0] chirp_fstart,
  output logic [PW-1:0] chirp_step,
  output logic          burst_busy,
  output logic          burst_done
);
  logic          rise;
  logic          load;
  logic          start_timer;
  logic          finish;
  logic [CW-1:0] width_q;
  logic [CW:0]   pri_q;
  logic [NW-1:0] count_q;

  pbc_trig_edge u_edge (
    .clk      (clk),
    .rst      (rst),
    .level_in (trig_bit),
    .rise     (rise)
  );

  pbc_burst_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .rise        (rise),
    .trig_level  (trig_bit),
    .count_zero  (cfg_count == '0),
    .finish      (finish),
    .load        (load),
    .start_timer (start_timer),
    .busy        (burst_busy),
    .done        (burst_done)
  );

  pbc_param_latch #(.CW(CW), .NW(NW), .PW(PW)) u_latch (
    .clk        (clk),
    .rst        (rst),
    .load       (load),
    .cfg_width  (cfg_width),
    .cfg_pri    (cfg_pri),
    .cfg_count  (cfg_count),
    .cfg_fstart (cfg_fstart),
    .cfg_step   (cfg_step),
    .width_q    (width_q),
    .pri_q      (pri_q),
    .count_q    (count_q),
    .fstart_q   (chirp_fstart),
    .step_q     (chirp_step)
  );

  pbc_pri_timer #(.CW(CW), .NW(NW)) u_timer (
    .clk         (clk),
    .rst         (rst),
    .start       (start_timer),
    .width       (width_q),
    .pri         (pri_q),
    .count       (count_q),
    .tx_active   (tx_active),
    .pulse_start (pulse_start),
    .finish      (finish)
  );

  // R10: the gate is only open during a burst
  a_r10_gate_in_burst: assert property (@(posedge clk) disable iff (rst)
    tx_active |-> burst_busy);
  // R5: busy and done never overlap
  a_r5_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(burst_busy && burst_done));
  // R9: chirp settings do not move inside a burst
  a_r9_chirp_frozen: assert property (@(posedge clk) disable iff (rst)
    (burst_busy && $past(burst_busy)) |-> ($stable(chirp_fstart) && $stable(chirp_step)));
endmodule

// File: tb/pulse_burst_ctrl_tb_top.sv
`timescale 1ns/1ps
module pulse_burst_ctrl_tb_top;
  localparam int CW = 16;
  localparam int NW = 8;
  localparam int PW = 32;

  typedef struct packed {
    logic tx;
    logic ps;
    logic busy;
    logic done;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          trig_bit = 1'b0;
  logic [CW-1:0] cfg_width = '0;
  logic [CW-1:0] cfg_pri = '0;
  logic [NW-1:0] cfg_count = '0;
  logic [PW-1:0] cfg_fstart = '0;
  logic [PW-1:0] cfg_step = '0;
  logic          tx_active, pulse_start, burst_busy, burst_done;
  logic [PW-1:0] chirp_fstart, chirp_step;

  int   checks = 0;
  int   fails = 0;
  bit   monitor_on = 1'b0;
  exp_t expq[$];

  always #4 clk = ~clk;

  pulse_burst_ctrl #(.CW(CW), .NW(NW), .PW(PW)) dut_i (
    .clk(clk), .rst(rst), .trig_bit(trig_bit),
    .cfg_width(cfg_width), .cfg_pri(cfg_pri), .cfg_count(cfg_count),
    .cfg_fstart(cfg_fstart), .cfg_step(cfg_step),
    .tx_active(tx_active), .pulse_start(pulse_start),
    .chirp_fstart(chirp_fstart), .chirp_step(chirp_step),
    .burst_busy(burst_busy), .burst_done(burst_done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp_v);
    end
  endtask

  // Monitor: compare each cycle after the clock edge against the scoreboard
  always @(posedge clk) begin
    #2;
    if (monitor_on && expq.size() > 0) begin
      exp_t e;
      exp_t a;
      e = expq.pop_front();
      a = '{tx: tx_active, ps: pulse_start, busy: burst_busy, done: burst_done};
      check(a == e, "R3/R4/R5/R10", "gate,strobe,busy,done", 64'(a), 64'(e));
    end
  end

  // Driver: sets settings, raises the trigger, queues the expected stream
  task automatic run_burst(input int w, input int p, input int n,
                           input logic [PW-1:0] fs, input logic [PW-1:0] st,
                           input int hold, input bit disturb);
    int we, pe, total;
    we = (w == 0) ? 1 : w;
    pe = (p <= we) ? we + 1 : p;
    total = n * pe;
    @(negedge clk);
    cfg_width  = CW'(w);
    cfg_pri    = CW'(p);
    cfg_count  = NW'(n);
    cfg_fstart = fs;
    cfg_step   = st;
    trig_bit   = 1'b1;
    for (int i = 0; i < total; i++) begin
      int pos;
      pos = i % pe;
      expq.push_back('{tx: (pos < we), ps: (pos == 0), busy: 1'b1, done: 1'b0});
    end
    for (int i = 0; i < hold; i++)
      expq.push_back('{tx: 1'b0, ps: 1'b0, busy: 1'b0, done: 1'b1});
    fork
      begin
        repeat (total + hold) @(negedge clk);
      end
      begin
        if (disturb) begin
          repeat (3) @(negedge clk);
          // R9: new settings and a trigger toggle mid-burst are ignored
          cfg_width  = CW'(1);
          cfg_pri    = CW'(3);
          cfg_count  = NW'(9);
          cfg_fstart = ~fs;
          cfg_step   = ~st;
          trig_bit   = 1'b0;
          @(negedge clk);
          trig_bit   = 1'b1;
          check(chirp_fstart == fs, "R9", "fstart during burst", 64'(chirp_fstart), 64'(fs));
          check(chirp_step == st, "R9", "step during burst", 64'(chirp_step), 64'(st));
        end
      end
    join
    // R9: chirp outputs hold this burst's snapshot
    check(chirp_fstart == fs, "R9", "fstart latched", 64'(chirp_fstart), 64'(fs));
    check(chirp_step == st, "R9", "step latched", 64'(chirp_step), 64'(st));
    // R6: trigger cleared, idle on the next cycle
    trig_bit = 1'b0;
    expq.push_back('{tx: 1'b0, ps: 1'b0, busy: 1'b0, done: 1'b0});
    @(negedge clk);
    @(negedge clk);
    check(expq.size() == 0, "R6", "scoreboard drained", 64'(expq.size()), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(tx_active == 1'b0, "R1", "tx_active", 64'(tx_active), 64'd0);
    check(pulse_start == 1'b0, "R1", "pulse_start", 64'(pulse_start), 64'd0);
    check(burst_busy == 1'b0, "R1", "busy", 64'(burst_busy), 64'd0);
    check(burst_done == 1'b0, "R1", "done", 64'(burst_done), 64'd0);
    check(chirp_fstart == '0, "R1", "fstart", 64'(chirp_fstart), 64'd0);
    monitor_on = 1'b1;

    // R2/R3: wide idle gap
    run_burst(3, 8, 2, 32'h1000_0001, 32'h0000_0010, 4, 1'b0);
    // R7: interval equal to width is clamped to width+1
    run_burst(5, 5, 3, 32'h2000_0002, 32'h0000_0020, 2, 1'b0);
    // R7: zero width acts as one cycle
    run_burst(0, 4, 2, 32'h3000_0003, 32'h0000_0030, 1, 1'b0);
    // R3: minimal pulse in a two-cycle interval
    run_burst(1, 2, 4, 32'h4000_0004, 32'h0000_0040, 1, 1'b0);
    // R8: zero pulses goes straight to done
    run_burst(2, 6, 0, 32'h5000_0005, 32'h0000_0050, 3, 1'b0);
    // R9: mid-burst writes and trigger toggle are ignored
    run_burst(4, 7, 3, 32'h6000_0006, 32'h0000_0060, 2, 1'b1);
    // R9: next burst picks up fresh settings; R2 edge after idle
    run_burst(2, 3, 2, 32'h7000_0007, 32'h0000_0070, 1, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule